// File: doc/BRIEF.md
# Iterative Coprocessor Multiplier

This unit sits beside a small processor core and executes the four integer multiply instructions. The core offers it an instruction through a coprocessor handshake: a valid flag, the 32-bit instruction word and the values of the two source registers. When the unit recognises the instruction as a multiply, it claims it by raising a busy flag one cycle later. This keeps the core's illegal-instruction timeout of 16 cycles from expiring. The unit then builds the 64-bit product with a shift-and-add loop. It returns one 32-bit word together with a write flag and a one-cycle ready pulse.

The low-word multiply only needs the lower half of the product, so it runs half as many iterations as the three high-word variants. The high-word variants differ only in how each operand is extended to 64 bits before the loop starts. The loop retires `STEP_BITS` multiplier bits per cycle. If the core withdraws the valid flag while the loop runs, the operation is abandoned and no result is returned.

Top module: `mulcp_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cp_wait`, `cp_ready` and `cp_wr` are low in the following cycle, even with a matching instruction offered.
- R2: An instruction is claimed only if bits [6:0] equal 0110011, bits [31:25] equal 0000001 and bit 14 is 0. Any other word offered with `cp_valid` high leaves `cp_wait`, `cp_ready` and `cp_wr` low.
- R3: `cp_wait` is high from the cycle after the first cycle in which a claimed instruction is offered, and stays high up to the ready cycle. In the ready cycle it is low.
- R4: When bits [14:12] are 000, the result is the low 32 bits of the product, and `cp_ready` is high in cycle XLEN/STEP_BITS+1, counted from the first offer cycle (cycle 33 with the defaults).
- R5: When bits [14:12] are 001, the result is the high 32 bits of the signed × signed product.
- R6: When bits [14:12] are 010, the result is the high 32 bits of the product of signed rs1 and unsigned rs2.
- R7: When bits [14:12] are 011, the result is the high 32 bits of the unsigned × unsigned product.
- R8: For the three high-word variants, `cp_ready` is high in cycle 2·XLEN/STEP_BITS+1, counted from the first offer cycle (cycle 65 with the defaults).
- R9: `cp_ready` and `cp_wr` are high together for exactly one cycle per completed operation, and `cp_rd` carries the result in that cycle.
- R10: When `cp_valid` is low at an edge while `cp_wait` is high, the unit returns to idle. `cp_wait` is low in the next cycle, no ready pulse follows, and a later instruction completes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_valid | input | 1 | Core offers an instruction |
| cp_insn | input | 32 | Offered instruction word |
| cp_rs1 | input | 32 | First source operand |
| cp_rs2 | input | 32 | Second source operand |
| cp_wr | output | 1 | Result is to be written to the destination register |
| cp_rd | output | 32 | Result word |
| cp_wait | output | 1 | Instruction claimed, work in progress |
| cp_ready | output | 1 | Operation finished, one-cycle pulse |

## Verification
The bench builds the unit with its defaults, XLEN = 32 and STEP_BITS = 1. One multiplier bit per cycle gives the longest loops, so the exact ready cycles 33 and 65 can be checked against the offer cycle. The operand set is walked through every variant and includes zero, all ones, the most negative value and the largest positive value. These values reach each sign-extension path and the carry into the top product bit. Directed cases cover reset with a matching offer, three kinds of near-miss encodings, and withdrawal of the valid flag mid-loop followed by a fresh operation.

// File: rtl/mulcp_pkg.sv
// Shared types for the coprocessor multiplier.
// Assumes the variant code equals bits [13:12] of the instruction word.
package mulcp_pkg;

    typedef enum logic [1:0] {
        MV_LO    = 2'b00,   // low word of product
        MV_HI_SS = 2'b01,   // high word, signed x signed
        MV_HI_SU = 2'b10,   // high word, signed x unsigned
        MV_HI_UU = 2'b11    // high word, unsigned x unsigned
    } mul_var_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } mul_state_e;

endpackage

// File: rtl/mulcp_decode.sv
// Instruction decoder: recognises the multiply encodings and names the variant.
// Purely combinational; assumes the full 32-bit instruction word is presented.
module mulcp_decode
    import mulcp_pkg::*;
(
    input  logic [31:0] insn,
    output logic        match,
    output mul_var_e    variant
);
    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] F7_MULDIV = 7'b0000001;

    logic unused_insn_bits;

    // Match opcode and funct7; funct3[2] set would mean a divide, so reject it.
    always_comb begin
        match   = (insn[6:0] == OPC_REG) && (insn[31:25] == F7_MULDIV) && !insn[14];
        variant = mul_var_e'(insn[13:12]);
    end

    assign unused_insn_bits = ^{insn[24:15], insn[11:7]};

endmodule

// File: rtl/mulcp_ctrl.sv
// Handshake controller: claims a decoded instruction, counts loop steps,
// aborts when valid drops, and emits the one-cycle ready pulse.
// Assumes the host holds valid until it sees ready.
module mulcp_ctrl
    import mulcp_pkg::*;
#(
    parameter int LO_STEPS = 32,
    parameter int HI_STEPS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic match,
    input  logic hi_word,
    output logic load,
    output logic step,
    output logic wait_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(HI_STEPS + 1);

    mul_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Strobes toward the datapath and handshake outputs.
    always_comb begin
        load    = (state == ST_IDLE) && valid && match;
        step    = (state == ST_RUN) && valid;
        wait_o  = (state == ST_RUN);
        ready_o = (state == ST_DONE);
    end

    // State and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (load) begin
                    state <= ST_RUN;
                    cnt   <= hi_word ? CNT_W'(HI_STEPS) : CNT_W'(LO_STEPS);
                end
                ST_RUN: begin
                    if (!valid) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                        if (cnt == CNT_W'(1)) state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: a claimed offer raises wait at the next edge.
    a_r3_claim_raises_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_o && !ready_o && valid && match) |=> wait_o);
    // R2: with no claimable offer, idle stays idle.
    a_r2_no_claim_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_o && !ready_o && !(valid && match)) |=> !wait_o);
    // R10: dropping valid mid-loop abandons the work.
    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && !valid) |=> (!wait_o && !ready_o));
    // R9: ready lasts one cycle.
    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
    // R3: ready is only reached through a busy period.
    a_r3_ready_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(wait_o));
    // R8: a running loop always has steps left.
    a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (cnt != '0));

endmodule

// File: rtl/mulcp_datapath.sv
// Shift-and-add datapath: extends operands per variant, accumulates
// STEP_BITS partial products per step, selects low or high product word.
// Assumes XLEN is a multiple of STEP_BITS.
module mulcp_datapath
    import mulcp_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int STEP_BITS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  mul_var_e        variant,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    output logic [XLEN-1:0] result
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0] mcand, mplier, acc, acc_next;
    mul_var_e      var_q;
    logic          a_sign, b_sign;

    // Operand sign extension chosen by variant.
    always_comb begin
        a_sign = rs1[XLEN-1] && ((variant == MV_HI_SS) || (variant == MV_HI_SU));
        b_sign = rs2[XLEN-1] && (variant == MV_HI_SS);
    end

    // Sum of this step's partial products.
    always_comb begin
        acc_next = acc;
        for (int j = 0; j < STEP_BITS; j++) begin
            if (mplier[j]) acc_next = acc_next + (mcand << j);
        end
    end

    // Operand registers and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            var_q  <= MV_LO;
        end else if (load) begin
            mcand  <= {{XLEN{a_sign}}, rs1};
            mplier <= {{XLEN{b_sign}}, rs2};
            acc    <= '0;
            var_q  <= variant;
        end else if (step) begin
            acc    <= acc_next;
            mcand  <= mcand << STEP_BITS;
            mplier <= mplier >> STEP_BITS;
        end
    end

    // Result word select.
    assign result = (var_q == MV_LO) ? acc[XLEN-1:0] : acc[PW-1:XLEN];

    // R4: loading always clears the accumulator.
    a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == '0));

endmodule

// File: rtl/mulcp_unit.sv
// Top of the coprocessor multiplier: decoder, controller and datapath.
// Assumes the host keeps operands and instruction stable while valid is high.
module mulcp_unit
    import mulcp_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int STEP_BITS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cp_valid,
    input  logic [31:0]     cp_insn,
    input  logic [XLEN-1:0] cp_rs1,
    input  logic [XLEN-1:0] cp_rs2,
    output logic            cp_wr,
    output logic [XLEN-1:0] cp_rd,
    output logic            cp_wait,
    output logic            cp_ready
);
    localparam int LO_STEPS = XLEN / STEP_BITS;
    localparam int HI_STEPS = 2 * XLEN / STEP_BITS;

    logic     match, load, step;
    mul_var_e variant;

    mulcp_decode u_decode (
        .insn    (cp_insn),
        .match   (match),
        .variant (variant)
    );

    mulcp_ctrl #(
        .LO_STEPS (LO_STEPS),
        .HI_STEPS (HI_STEPS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cp_valid),
        .match   (match),
        .hi_word (variant != MV_LO),
        .load    (load),
        .step    (step),
        .wait_o  (cp_wait),
        .ready_o (cp_ready)
    );

    mulcp_datapath #(
        .XLEN      (XLEN),
        .STEP_BITS (STEP_BITS)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .variant (variant),
        .rs1     (cp_rs1),
        .rs2     (cp_rs2),
        .result  (cp_rd)
    );

    // Write request accompanies every completion.
    assign cp_wr = cp_ready;

    // R1: reset leaves the handshake quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cp_wait && !cp_ready && !cp_wr));

endmodule

// File: tb/test_mulcp_unit.sv
module test_mulcp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // {funct3, rs1, rs2}
    localparam logic [66:0] VEC [NVEC] = '{
        {3'b000, 32'h0000_0007, 32'h0000_0006},
        {3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'b000, 32'h8000_0000, 32'h0000_0002},
        {3'b000, 32'h1234_5678, 32'h9ABC_DEF0},
        {3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'b001, 32'h8000_0000, 32'h8000_0000},
        {3'b001, 32'h7FFF_FFFF, 32'h8000_0000},
        {3'b001, 32'hDEAD_BEEF, 32'h0BAD_F00D},
        {3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'b010, 32'h8000_0000, 32'hFFFF_FFFF},
        {3'b010, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {3'b010, 32'h0000_0000, 32'hCAFE_BABE},
        {3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'b011, 32'h8000_0000, 32'h8000_0000},
        {3'b011, 32'h0001_0000, 32'h0001_0000},
        {3'b011, 32'hA5A5_A5A5, 32'h5A5A_5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic        wr, wt, rdy;
    logic [31:0] rd;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mulcp_unit i_mulcp_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cp_valid (valid),
        .cp_insn  (insn),
        .cp_rs1   (rs1),
        .cp_rs2   (rs2),
        .cp_wr    (wr),
        .cp_rd    (rd),
        .cp_wait  (wt),
        .cp_ready (rdy)
    );

    function automatic logic [31:0] mk_insn(input logic [2:0] f3);
        return {7'b0000001, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
    endfunction

    // Independent reference: extend, multiply modulo 2^64, pick a word.
    function automatic logic [31:0] ref_mul(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = {{32{a[31] && (f3 == 3'b001 || f3 == 3'b010)}}, a};
        eb = {{32{b[31] && (f3 == 3'b001)}}, b};
        p  = ea * eb;
        return (f3 == 3'b000) ? p[31:0] : p[63:32];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        int lat;
        int k;
        bit wait_ok;
        string tag;
        exp = ref_mul(f3, a, b);
        lat = (f3 == 3'b000) ? 33 : 65;
        case (f3)
            3'b000:  tag = "R4 low product";
            3'b001:  tag = "R5 high signed x signed";
            3'b010:  tag = "R6 high signed x unsigned";
            default: tag = "R7 high unsigned x unsigned";
        endcase
        @(negedge clk);
        valid = 1'b1; insn = mk_insn(f3); rs1 = a; rs2 = b;
        @(negedge clk);
        k = 1;
        check(wt == 1'b1, "R3 wait in cycle after offer", 32'(wt), 32'd1);
        wait_ok = 1'b1;
        while (!rdy && k < 100) begin
            if (!wt) wait_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        check(k == lat, (f3 == 3'b000) ? "R4 ready cycle" : "R8 ready cycle", 32'(k), 32'(lat));
        check(rd == exp, tag, rd, exp);
        check(wr == 1'b1, "R9 write with ready", 32'(wr), 32'd1);
        check(wt == 1'b0 && wait_ok, "R3 wait held until ready then low", 32'(wt), 32'd0);
        valid = 1'b0;
        @(negedge clk);
        check(rdy == 1'b0 && wr == 1'b0, "R9 single-cycle pulse", {30'd0, rdy, wr}, 32'd0);
    endtask

    task automatic offer_unclaimed(input logic [31:0] word, input string req);
        bit quiet;
        @(negedge clk);
        valid = 1'b1; insn = word; rs1 = 32'h1234_5678; rs2 = 32'h0000_0003;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wt || rdy || wr) quiet = 1'b0;
        end
        check(quiet, req, {29'd0, wt, rdy, wr}, 32'd0);
        valid = 1'b0;
    endtask

    initial begin
        // R1: reset with a matching offer present.
        valid = 1'b1; insn = mk_insn(3'b000); rs1 = 32'd5; rs2 = 32'd6;
        repeat (3) @(negedge clk);
        check(!wt && !rdy && !wr, "R1 reset quiet", {29'd0, wt, rdy, wr}, 32'd0);
        valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check(!wt && !rdy && !wr, "R1 idle after reset", {29'd0, wt, rdy, wr}, 32'd0);

        // Main table walk (R4..R9).
        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][66:64], VEC[v][63:32], VEC[v][31:0]);
        end

        // R2: near-miss encodings are not claimed.
        offer_unclaimed({7'b0000001, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011}, "R2 divide funct3 ignored");
        offer_unclaimed({7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, "R2 plain add ignored");
        offer_unclaimed({7'b0000001, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0010011}, "R2 other opcode ignored");

        // R10: abort mid-loop, then recover.
        @(negedge clk);
        valid = 1'b1; insn = mk_insn(3'b001); rs1 = 32'hFFFF_0000; rs2 = 32'h0000_FFFF;
        repeat (10) @(negedge clk);
        check(wt == 1'b1, "R10 busy before abort", 32'(wt), 32'd1);
        valid = 1'b0;
        @(negedge clk);
        check(wt == 1'b0, "R10 wait low after abort", 32'(wt), 32'd0);
        begin
            bit no_rdy;
            no_rdy = 1'b1;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (rdy || wr || wt) no_rdy = 1'b0;
            end
            check(no_rdy, "R10 no ready after abort", {29'd0, wt, rdy, wr}, 32'd0);
        end
        run_op(3'b011, 32'hFFFF_0000, 32'h0000_FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule